// File: doc/BRIEF.md
# Sync Source Scanner and Lock Monitor

This block picks which of two sliced digital sync streams carries a usable horizontal line rate, then watches that stream and reports whether sync is still present. One stream is the sync sliced out of a composite or luma/green signal; the other is a separate horizontal sync line. Software-free control comes from two source enables, a 3-bit mode code and an override that keeps the downstream timing outputs on even without lock.

Every line period is measured in cycles of the free-running reference clock, from one rising edge of the selected stream to the next. A first period within the legal rate range gives "rate acquired". Three further lines, each within one sixteenth of the period accepted before it, raise the lock flag. Once locked, the flag only drops after a long run of missing or off-period lines. Scanning then starts again.

Top module: `ssl_scan_lock`

## Requirements
- R1: Each input passes through two synchronizing registers before its rising edges are used. A line period is the number of reference cycles between two rising edges of the selected stream. With the default 50 MHz reference, a period is acceptable for acquisition only from 333 to 4651 cycles inclusive, which corresponds to 150 kHz down to 10.75 kHz.
- R2: With both enables set, scanning starts on the composite stream (src_sel = 0). If a listening window of 16000 cycles passes without acquisition, src_sel toggles (1 = separate horizontal stream) and a fresh window starts. The toggling repeats until one stream qualifies.
- R3: With exactly one enable set, src_sel follows that input within one cycle while scanning. No toggling happens, and the other stream is ignored even if it carries valid sync.
- R4: rate_ok rises when the selected stream shows an acceptable period, measured from two edges seen since the last source change. While rate_ok is high, src_sel does not change.
- R5: After acquisition, a line is good when its period differs from the last accepted period by at most that period shifted right by 4; a good line becomes the new accepted period. sync_lock rises on the third consecutive good line. Before lock, a bad period or a timeout sends the block back to scanning on the same stream.
- R6: A missing line is counted while locked in two cases: an edge arrives whose period is off tolerance, or no edge arrives within 1.5 times the accepted period (the timer then restarts). A good line clears the count. The 21st consecutive missing line clears sync_lock and rate_ok and restarts scanning.
- R7: out_gate is high one cycle after force_out_en or sync_lock is high, and low otherwise.
- R8: type_ctl follows mode one cycle later. Its bits are [5] tri-level enable, [4] bi-level enable, [3] separate H/V enable, [2] tri-level priority, [1] H-input priority and [0] H/V-only. The codes decode as follows: 000 to 111000, 001 to 011000, 010 to 111100, 011 to 100100, 100 to 010000, 101 to 111010, 110 to 011010, and 111 to 011011.
- R9: A synchronous active-high reset drives src_sel, rate_ok, sync_lock, out_gate and type_ctl to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_sync | input | 1 | Sliced sync from the composite/luma input, high during sync |
| hsep_sync | input | 1 | Sliced separate horizontal sync, high during sync |
| comp_en | input | 1 | Allows the composite stream to be scanned |
| hsep_en | input | 1 | Allows the separate horizontal stream to be scanned |
| mode | input | 3 | Sync-type control code |
| force_out_en | input | 1 | Keeps the timing-output gate open regardless of lock |
| src_sel | output | 1 | Selected stream: 0 composite, 1 separate horizontal |
| rate_ok | output | 1 | A legal line rate has been acquired |
| sync_lock | output | 1 | Sync locked |
| out_gate | output | 1 | Enable for the downstream timing outputs |
| type_ctl | output | 6 | Decoded sync-type enables and priorities |

## Verification
Lines are fed at a steady 400-cycle period, at the two legal extremes of 333 and 4651 cycles, and at periods just outside the legal range. These runs separate the range test from the tolerance test. A pattern with a 25-cycle step, and another that alternates between 400 and 480 cycles, tell a period change that is just tolerated apart from jitter that must keep lock away. A silent composite stream next to an active separate stream exercises the window switching. An active composite stream that is disabled shows it is ignored. A long gap after lock pins the drop to the 21st missing line.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

  // next-state action chosen by the lock controller each cycle
  typedef enum logic [3:0] {
    ACT_FIX,    // scanning: move to the only enabled stream
    ACT_ACQ,    // scanning: legal period seen, rate acquired
    ACT_SWAP,   // scanning: window over, try the other stream
    ACT_WRAP,   // scanning: window over, single stream, keep going
    ACT_STEP,   // scanning: window continues
    ACT_GOOD,   // tracking: line within tolerance
    ACT_MISS,   // tracking (locked): missing or off-period line
    ACT_DROP,   // tracking (unlocked): give up, scan again
    ACT_WAIT    // tracking: nothing happened
  } act_e;

  localparam int CTL_W = 6;

  function automatic logic [CTL_W-1:0] decode_mode(input logic [2:0] m);
    logic [CTL_W-1:0] r;
    case (m)
      3'b000:  r = 6'b111000;
      3'b001:  r = 6'b011000;
      3'b010:  r = 6'b111100;
      3'b011:  r = 6'b100100;
      3'b100:  r = 6'b010000;
      3'b101:  r = 6'b111010;
      3'b110:  r = 6'b011010;
      default: r = 6'b011011;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ssl_edge_det.sv
module ssl_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic [2:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[1:0], din[i]};
    end
    assign rise[i] = pipe[1] & ~pipe[2];
  end
endmodule

// File: rtl/ssl_period_meter.sv
module ssl_period_meter #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          edge_i,
  output logic [CW-1:0] per
);
  always_ff @(posedge clk) begin
    if (rst || clr)        per <= '0;
    else if (edge_i)       per <= CW'(1);
    else if (per != '1)    per <= per + CW'(1);
  end
endmodule

// File: rtl/ssl_mode_dec.sv
module ssl_mode_dec
  import ssl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  output logic [CTL_W-1:0] ctl
);
  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else     ctl <= decode_mode(mode);
  end
endmodule

// File: rtl/ssl_lock_ctrl.sv
module ssl_lock_ctrl
  import ssl_pkg::*;
#(
  parameter int CW         = 14,
  parameter int WIN_CYC    = 16000,
  parameter int MIN_PER    = 333,
  parameter int MAX_PER    = 4651,
  parameter int LOCK_GOOD  = 3,
  parameter int LOSS_LINES = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          comp_en,
  input  logic          hsep_en,
  input  logic [1:0]    rise,
  input  logic [CW-1:0] per,
  output logic          sel_edge,
  output logic          meter_clr,
  output logic          src_sel,
  output logic          rate_ok,
  output logic          sync_lock
);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int GW = $clog2(LOCK_GOOD + 1);
  localparam int MW = $clog2(LOSS_LINES + 1);

  logic [CW-1:0] ref_per;
  logic [GW-1:0] good_cnt;
  logic [MW-1:0] miss_cnt;
  logic [WW-1:0] win_cnt;
  logic [CW:0]   gap_cnt;
  logic          have_prev;

  logic [CW:0]   thr;
  logic [CW-1:0] diff;
  logic          in_tol, in_rng, one_src, win_end, miss_tick;
  act_e          act;

  assign sel_edge  = src_sel ? rise[1] : rise[0];
  assign thr       = {1'b0, ref_per} + {2'b00, ref_per[CW-1:1]};
  assign diff      = (per >= ref_per) ? per - ref_per : ref_per - per;
  assign in_tol    = diff <= (ref_per >> 4);
  assign in_rng    = (per >= CW'(MIN_PER)) && (per <= CW'(MAX_PER));
  assign one_src   = comp_en ^ hsep_en;
  assign win_end   = win_cnt == WW'(WIN_CYC - 1);
  assign miss_tick = gap_cnt == thr - (CW+1)'(1);

  always_comb begin
    if (!rate_ok) begin
      if (one_src && (src_sel != hsep_en))       act = ACT_FIX;
      else if (sel_edge && have_prev && in_rng)  act = ACT_ACQ;
      else if (win_end && comp_en && hsep_en)    act = ACT_SWAP;
      else if (win_end)                          act = ACT_WRAP;
      else                                       act = ACT_STEP;
    end else if (sel_edge) begin
      if (in_tol)         act = ACT_GOOD;
      else if (sync_lock) act = ACT_MISS;
      else                act = ACT_DROP;
    end else if (miss_tick) begin
      act = sync_lock ? ACT_MISS : ACT_DROP;
    end else begin
      act = ACT_WAIT;
    end
  end

  assign meter_clr = (act == ACT_FIX) || (act == ACT_SWAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel   <= 1'b0;
      rate_ok   <= 1'b0;
      sync_lock <= 1'b0;
      ref_per   <= '0;
      good_cnt  <= '0;
      miss_cnt  <= '0;
      win_cnt   <= '0;
      gap_cnt   <= '0;
      have_prev <= 1'b0;
    end else begin
      case (act)
        ACT_FIX: begin
          src_sel   <= hsep_en;
          win_cnt   <= '0;
          have_prev <= 1'b0;
          gap_cnt   <= '0;
        end
        ACT_ACQ: begin
          rate_ok  <= 1'b1;
          ref_per  <= per;
          good_cnt <= '0;
          miss_cnt <= '0;
          win_cnt  <= '0;
          gap_cnt  <= '0;
        end
        ACT_SWAP: begin
          src_sel   <= ~src_sel;
          win_cnt   <= '0;
          have_prev <= 1'b0;
          gap_cnt   <= '0;
        end
        ACT_WRAP: begin
          win_cnt <= '0;
          gap_cnt <= '0;
          if (sel_edge) have_prev <= 1'b1;
        end
        ACT_STEP: begin
          win_cnt <= win_cnt + WW'(1);
          gap_cnt <= '0;
          if (sel_edge) have_prev <= 1'b1;
        end
        ACT_GOOD: begin
          gap_cnt  <= '0;
          ref_per  <= per;
          miss_cnt <= '0;
          if (!sync_lock) begin
            if (good_cnt == GW'(LOCK_GOOD - 1)) sync_lock <= 1'b1;
            else                                good_cnt  <= good_cnt + GW'(1);
          end
        end
        ACT_MISS: begin
          gap_cnt <= '0;
          if (miss_cnt == MW'(LOSS_LINES)) begin
            sync_lock <= 1'b0;
            rate_ok   <= 1'b0;
            win_cnt   <= '0;
            have_prev <= 1'b0;
            good_cnt  <= '0;
            miss_cnt  <= '0;
          end else begin
            miss_cnt <= miss_cnt + MW'(1);
          end
        end
        ACT_DROP: begin
          gap_cnt   <= '0;
          rate_ok   <= 1'b0;
          win_cnt   <= '0;
          have_prev <= sel_edge;
          good_cnt  <= '0;
        end
        default: gap_cnt <= gap_cnt + (CW+1)'(1);
      endcase
    end
  end
endmodule

// File: rtl/ssl_scan_lock.sv
module ssl_scan_lock
  import ssl_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int LOCK_GOOD  = 3,
  parameter int LOSS_LINES = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             comp_sync,
  input  logic             hsep_sync,
  input  logic             comp_en,
  input  logic             hsep_en,
  input  logic [2:0]       mode,
  input  logic             force_out_en,
  output logic             src_sel,
  output logic             rate_ok,
  output logic             sync_lock,
  output logic             out_gate,
  output logic [CTL_W-1:0] type_ctl
);
  // 320 us window, 150 kHz fastest and 10.75 kHz slowest line rate
  localparam int WIN_CYC = CLK_HZ / 3125;
  localparam int MIN_PER = CLK_HZ / 150_000;
  localparam int MAX_PER = (CLK_HZ / 43_000) * 4 + ((CLK_HZ % 43_000) * 4) / 43_000;
  localparam int CW      = $clog2(2 * MAX_PER + 1);

  logic [1:0]    rise;
  logic          sel_edge, meter_clr;
  logic [CW-1:0] per;

  ssl_edge_det #(.N(2)) u_edge (
    .clk (clk),
    .rst (rst),
    .din ({hsep_sync, comp_sync}),
    .rise(rise)
  );

  ssl_period_meter #(.CW(CW)) u_meter (
    .clk   (clk),
    .rst   (rst),
    .clr   (meter_clr),
    .edge_i(sel_edge),
    .per   (per)
  );

  ssl_lock_ctrl #(
    .CW(CW), .WIN_CYC(WIN_CYC), .MIN_PER(MIN_PER), .MAX_PER(MAX_PER),
    .LOCK_GOOD(LOCK_GOOD), .LOSS_LINES(LOSS_LINES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .comp_en  (comp_en),
    .hsep_en  (hsep_en),
    .rise     (rise),
    .per      (per),
    .sel_edge (sel_edge),
    .meter_clr(meter_clr),
    .src_sel  (src_sel),
    .rate_ok  (rate_ok),
    .sync_lock(sync_lock)
  );

  ssl_mode_dec u_mode (
    .clk (clk),
    .rst (rst),
    .mode(mode),
    .ctl (type_ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) out_gate <= 1'b0;
    else     out_gate <= force_out_en | sync_lock;
  end
endmodule

// File: rtl/ssl_scan_lock_chk.sv
module ssl_scan_lock_chk (
  input logic       clk,
  input logic       rst,
  input logic       comp_en,
  input logic       hsep_en,
  input logic [2:0] mode,
  input logic       force_out_en,
  input logic       src_sel,
  input logic       rate_ok,
  input logic       sync_lock,
  input logic       out_gate,
  input logic [5:0] type_ctl
);
  assert_lock_needs_rate_R5: assert property (@(posedge clk) disable iff (rst)
    sync_lock |-> rate_ok);

  assert_lock_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_lock) |-> $past(rate_ok));

  assert_lock_fall_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_lock) |-> !rate_ok);

  assert_src_hold_R4: assert property (@(posedge clk) disable iff (rst)
    rate_ok |=> $stable(src_sel));

  assert_single_src_R3: assert property (@(posedge clk) disable iff (rst)
    (!rate_ok && (comp_en ^ hsep_en)) |=> (src_sel == $past(hsep_en)));

  assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_gate == ($past(force_out_en) || $past(sync_lock))));

  assert_mode_000_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000) |=> (type_ctl == 6'b111000));

  assert_mode_011_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b011) |=> (type_ctl == 6'b100100));

  assert_mode_111_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b111) |=> (type_ctl == 6'b011011));
endmodule

bind ssl_scan_lock ssl_scan_lock_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .comp_en     (comp_en),
  .hsep_en     (hsep_en),
  .mode        (mode),
  .force_out_en(force_out_en),
  .src_sel     (src_sel),
  .rate_ok     (rate_ok),
  .sync_lock   (sync_lock),
  .out_gate    (out_gate),
  .type_ctl    (type_ctl)
);

// File: tb/sim_ssl_scan_lock.sv
module sim_ssl_scan_lock;
  localparam int P_MIN = 333;
  localparam int P_MAX = 4651;
  localparam int WIN   = 16000;
  localparam int SAT   = 16383;
  localparam int NGOOD = 3;
  localparam int NLOSS = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic comp_sync = 1'b0, hsep_sync = 1'b0;
  logic comp_en = 1'b1, hsep_en = 1'b0, force_out_en = 1'b0;
  logic [2:0] mode = 3'b000;
  logic src_sel, rate_ok, sync_lock, out_gate;
  logic [5:0] type_ctl;

  always #10 clk = ~clk;

  ssl_scan_lock u0 (
    .clk(clk), .rst(rst), .comp_sync(comp_sync), .hsep_sync(hsep_sync),
    .comp_en(comp_en), .hsep_en(hsep_en), .mode(mode), .force_out_en(force_out_en),
    .src_sel(src_sel), .rate_ok(rate_ok), .sync_lock(sync_lock),
    .out_gate(out_gate), .type_ctl(type_ctl)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  int c1, c2, c3, h1, h2, h3;
  int m_src, m_rate, m_lock, m_ref, m_good, m_miss, m_win, m_prev, m_gap, m_per, m_gate, m_ctl;

  function automatic int ctl_of(input int m);
    case (m)
      0: return 6'b111000;
      1: return 6'b011000;
      2: return 6'b111100;
      3: return 6'b100100;
      4: return 6'b010000;
      5: return 6'b111010;
      6: return 6'b011010;
      default: return 6'b011011;
    endcase
  endfunction

  always @(posedge clk) begin
    int ec, eh, e, d, clr;
    cyc++;
    if (rst) begin
      c1 = 0; c2 = 0; c3 = 0; h1 = 0; h2 = 0; h3 = 0;
      m_src = 0; m_rate = 0; m_lock = 0; m_ref = 0; m_good = 0; m_miss = 0;
      m_win = 0; m_prev = 0; m_gap = 0; m_per = 0; m_gate = 0; m_ctl = 0;
    end else begin
      ec = (c2 == 1 && c3 == 0) ? 1 : 0;
      eh = (h2 == 1 && h3 == 0) ? 1 : 0;
      e  = m_src ? eh : ec;
      m_gate = (force_out_en || m_lock != 0) ? 1 : 0;
      m_ctl  = ctl_of(int'(mode));
      clr = 0;
      if (m_rate == 0) begin
        m_gap = 0;
        if ((comp_en != hsep_en) && m_src != int'(hsep_en)) begin
          m_src = int'(hsep_en); m_win = 0; m_prev = 0; clr = 1;
        end else if (e && m_prev && m_per >= P_MIN && m_per <= P_MAX) begin
          m_rate = 1; m_ref = m_per; m_good = 0; m_miss = 0; m_win = 0;
        end else if (m_win == WIN - 1) begin
          m_win = 0;
          if (comp_en && hsep_en) begin m_src = 1 - m_src; m_prev = 0; clr = 1; end
          else if (e) m_prev = 1;
        end else begin
          m_win++;
          if (e) m_prev = 1;
        end
      end else begin
        d = m_per - m_ref;
        if (d < 0) d = -d;
        if (e && d <= m_ref / 16) begin
          m_gap = 0; m_ref = m_per; m_miss = 0;
          if (!m_lock) begin
            if (m_good == NGOOD - 1) m_lock = 1;
            else m_good++;
          end
        end else if (e || m_gap == m_ref + m_ref / 2 - 1) begin
          m_gap = 0;
          if (m_lock) begin
            if (m_miss == NLOSS) begin
              m_lock = 0; m_rate = 0; m_win = 0; m_prev = 0; m_good = 0; m_miss = 0;
            end else m_miss++;
          end else begin
            m_rate = 0; m_win = 0; m_prev = e; m_good = 0;
          end
        end else m_gap++;
      end
      if (clr) m_per = 0;
      else if (e) m_per = 1;
      else if (m_per < SAT) m_per++;
      c3 = c2; c2 = c1; c1 = int'(comp_sync);
      h3 = h2; h2 = h1; h1 = int'(hsep_sync);
    end
    if (cyc > 190000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      bit bad;
      bad = 0;
      n_cmp++;
      if (src_sel !== 1'(m_src)) begin bad = 1;
        $display("FAIL R2/R3 src_sel actual=%0b expected=%0d", src_sel, m_src); end
      if (rate_ok !== 1'(m_rate)) begin bad = 1;
        $display("FAIL R4 rate_ok actual=%0b expected=%0d", rate_ok, m_rate); end
      if (sync_lock !== 1'(m_lock)) begin bad = 1;
        $display("FAIL R5/R6 sync_lock actual=%0b expected=%0d", sync_lock, m_lock); end
      if (out_gate !== 1'(m_gate)) begin bad = 1;
        $display("FAIL R7 out_gate actual=%0b expected=%0d", out_gate, m_gate); end
      if (type_ctl !== 6'(m_ctl)) begin bad = 1;
        $display("FAIL R8 type_ctl actual=%b expected=%b", type_ctl, 6'(m_ctl)); end
      if (bad) n_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit on_h, input int p);
    for (int i = 0; i < p; i++) begin
      if (on_h) hsep_sync = (i < 20);
      else      comp_sync = (i < 20);
      @(negedge clk);
    end
  endtask

  task automatic lines(input bit on_h, input int p, input int n);
    for (int k = 0; k < n; k++) pulse(on_h, p);
  endtask

  task automatic do_reset(input bit ce, input bit he);
    rst = 1'b1; comp_en = ce; hsep_en = he;
    idle(4);
    rst = 1'b0;
  endtask

  initial begin
    idle(4);
    chk(src_sel === 1'b0 && rate_ok === 1'b0, "R9 reset src/rate", int'(src_sel), 0);
    chk(sync_lock === 1'b0 && out_gate === 1'b0, "R9 reset lock/gate", int'(sync_lock), 0);
    chk(type_ctl === 6'b0, "R9 reset type_ctl", int'(type_ctl), 0);
    rst = 1'b0;

    for (int m = 0; m < 8; m++) begin mode = 3'(m); idle(2); end
    mode = 3'b000; idle(2);
    chk(type_ctl === 6'b111000, "R8 code 000", int'(type_ctl), 56);
    mode = 3'b011; idle(2);
    chk(type_ctl === 6'b100100, "R8 code 011", int'(type_ctl), 36);
    mode = 3'b111; idle(2);
    chk(type_ctl === 6'b011011, "R8 code 111", int'(type_ctl), 27);
    mode = 3'b000;

    // steady composite lines, composite only
    lines(0, 400, 10);
    chk(sync_lock === 1'b1, "R5 lock on steady 400", int'(sync_lock), 1);
    chk(src_sel === 1'b0, "R3 composite-only select", int'(src_sel), 0);
    // long gap: lock holds through 20 misses, drops at the 21st
    idle(11000);
    chk(sync_lock === 1'b1, "R6 lock held before 21st miss", int'(sync_lock), 1);
    idle(2000);
    chk(sync_lock === 1'b0 && rate_ok === 1'b0, "R6 lock lost", int'(sync_lock), 0);
    force_out_en = 1'b1; idle(3);
    chk(out_gate === 1'b1, "R7 override opens gate", int'(out_gate), 1);
    force_out_en = 1'b0; idle(3);
    chk(out_gate === 1'b0, "R7 gate closed unlocked", int'(out_gate), 0);

    // out-of-range rates
    do_reset(1, 0);
    lines(0, 200, 20);
    chk(rate_ok === 1'b0, "R1 period 200 rejected", int'(rate_ok), 0);
    do_reset(1, 0);
    lines(0, 5000, 4);
    chk(rate_ok === 1'b0, "R1 period 5000 rejected", int'(rate_ok), 0);

    // legal extremes
    do_reset(1, 0);
    lines(0, P_MIN, 8);
    chk(sync_lock === 1'b1, "R1 period 333 locks", int'(sync_lock), 1);
    do_reset(1, 0);
    lines(0, P_MAX, 6);
    chk(sync_lock === 1'b1, "R1 period 4651 locks", int'(sync_lock), 1);

    // tolerance edge: a 25-cycle step on a 400 period is accepted
    do_reset(1, 0);
    pulse(0, 400); pulse(0, 400); pulse(0, 425); pulse(0, 425); pulse(0, 425);
    chk(sync_lock === 1'b1, "R5 step of ref/16 tolerated", int'(sync_lock), 1);

    // jitter beyond tolerance keeps lock away
    do_reset(1, 0);
    for (int k = 0; k < 8; k++) begin pulse(0, 400); pulse(0, 480); end
    chk(sync_lock === 1'b0, "R5 400/480 jitter no lock", int'(sync_lock), 0);

    // both enabled, composite silent: scanner moves to separate stream
    do_reset(1, 1);
    idle(50);
    chk(src_sel === 1'b0, "R2 composite watched first", int'(src_sel), 0);
    lines(1, 1000, 24);
    chk(src_sel === 1'b1, "R2 switched to separate", int'(src_sel), 1);
    chk(sync_lock === 1'b1, "R2 lock on separate", int'(sync_lock), 1);

    // separate only enabled, valid composite activity is ignored
    do_reset(0, 1);
    lines(0, 400, 20);
    chk(src_sel === 1'b1, "R3 separate-only select", int'(src_sel), 1);
    chk(rate_ok === 1'b0, "R3 disabled composite ignored", int'(rate_ok), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule